// File: doc/BRIEF.md
# Boot Sector Write-Protection Controller

This block is the permission logic that sits beside the array of a byte-wide flash memory model with a 20-bit address space. The array keeps one fixed 16 KB boot sector. The block watches every bus write and every program or chip-erase request. For each request it decides whether the request may go ahead. The array model acts on the grants; it does not repeat the checks.

The block holds a sticky lockout flag. A six-write command sequence sets it, and only the block's reset clears it, which models nonvolatile storage. A three-write command puts the block into an identification mode and a matching command takes it out again. While that mode is active, a read of one fixed address returns the lockout state. A live high-voltage override input lets the locked boot sector be written only for as long as it is held.

Electrical signals arrive already reduced to logic levels. These are chip enable, write enable, output enable, supply-low and override. The parameter `BOOT_TOP` places the boot sector at the bottom or at the top of the address space.

Top module: `bootprot_ctrl`

## Requirements
- R1: The boot sector is 0x00000 to 0x03FFF when `BOOT_TOP`=0, and 0xFC000 to 0xFFFFF when `BOOT_TOP`=1. Every other address lies outside it.
- R2: When no inhibit is present, a program request to an address outside the boot sector is always granted. `prog_grant` goes high exactly one cycle after `prog_req`.
- R3: A request is inhibited when `oe_act`=1, `ce_act`=0, `we_act`=0 or `supply_low`=1. An inhibited program or erase request gets no grant. An inhibited command write has no effect on the command tracker.
- R4: The writes (address/data) 0x5555/AA, 0x2AAA/55, 0x5555/80, 0x5555/AA, 0x2AAA/55, 0x5555/40, in that order, set `locked` one cycle after the sixth write. After that, a program request to the boot sector is rejected unless the override is active.
- R5: Any write that does not match the next expected step returns the tracker to idle. The sequence must then start again from its first write.
- R6: While `hv_override`=1, program requests to a locked boot sector are granted. Once it returns to 0, they are rejected again.
- R7: The writes 0x5555/AA, 0x2AAA/55, 0x5555/90 set `id_mode` one cycle after the third write. The same sequence ending in data 0xF0 clears it.
- R8: In identification mode, a read request to address 0x00002 gives `stat_valid`=1 one cycle later, with `stat_data` bit 0 equal to the lockout flag (1 = locked) and the other bits 0. Other addresses, or any read outside identification mode, give `stat_valid`=0.
- R9: A chip erase request that is not inhibited raises `erase_grant` one cycle later. `erase_boot` is raised with it only if the sector is unlocked or the override is held. An erase never clears `locked`.
- R10: After reset, `locked`, `id_mode` and all grant and status outputs are 0. Once set, `locked` stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also clears the lockout flag |
| wr_req | input | 1 | Bus write strobe (command write), one cycle |
| prog_req | input | 1 | Byte program request, one cycle |
| erase_req | input | 1 | Chip erase request, one cycle |
| rd_req | input | 1 | Read request, one cycle |
| addr | input | 20 | Address for the write, program or read |
| wdata | input | 8 | Data for a command write |
| ce_act | input | 1 | Chip enable is active |
| we_act | input | 1 | Write enable is active |
| oe_act | input | 1 | Output enable is active |
| supply_low | input | 1 | Supply is below the program threshold |
| hv_override | input | 1 | High-voltage override on the reset pin is present |
| prog_grant | output | 1 | Program request allowed |
| erase_grant | output | 1 | Chip erase allowed |
| erase_boot | output | 1 | Chip erase may include the boot sector |
| locked | output | 1 | Lockout flag |
| id_mode | output | 1 | Identification mode active |
| stat_valid | output | 1 | Status read result valid |
| stat_data | output | 8 | Status read data |

## Verification
Each result comes from a single register stage, so it is due on the first rising edge after the input was presented. This covers the grants, the lockout flag, the identification-mode flag and the status read. The bench changes inputs on the falling edge. It drops them on the next falling edge and samples there, exactly half a cycle after the edge that registered the result. A second instance with top placement shares the same stimulus. Sweeps with the sector locked and unlocked then compare both instances against a range computed in the bench.

// File: rtl/bootprot_pkg.sv
// Shared constants and types for the boot sector protection controller.
// Assumes the command keys fit into the low 16 bits of the address.
package bootprot_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_K1,
        SEQ_K2,
        SEQ_L3,
        SEQ_L4,
        SEQ_L5
    } seq_state_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DAT_1  = 8'hAA;
    localparam logic [7:0]  KEY_DAT_2  = 8'h55;
    localparam logic [7:0]  CMD_LOCK_PRE = 8'h80;
    localparam logic [7:0]  CMD_LOCK_FIN = 8'h40;
    localparam logic [7:0]  CMD_ID_ENTER = 8'h90;
    localparam logic [7:0]  CMD_ID_LEAVE = 8'hF0;
endpackage

// File: rtl/bootprot_range.sv
// Boot sector address decode. The sector is 2**BOOT_LOG2 bytes and sits at the
// bottom (BOOT_TOP=0) or the top (BOOT_TOP=1) of the address space.
// Assumes BOOT_LOG2 < ADDR_W. Purely combinational.
module bootprot_range #(
    parameter int ADDR_W    = 20,
    parameter int BOOT_LOG2 = 14,
    parameter bit BOOT_TOP  = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_boot
);
    localparam int HI_W = ADDR_W - BOOT_LOG2;

    logic [HI_W-1:0] upper;
    assign upper = addr[ADDR_W-1:BOOT_LOG2];

    generate
        if (BOOT_TOP) begin : g_top
            // Sector occupies the highest block: upper bits all ones.
            assign in_boot = &upper;
        end else begin : g_bottom
            // Sector occupies the lowest block: upper bits all zeros.
            assign in_boot = ~|upper;
        end
    endgenerate
endmodule

// File: rtl/bootprot_seq.sv
// Command sequence tracker. It consumes qualified command writes, recognises
// the lockout and identification entry/exit sequences, and holds the sticky
// lockout flag and the identification mode flag.
// Assumes wr_en is already gated by the inhibit conditions.
module bootprot_seq #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              locked,
    output logic              id_mode
);
    import bootprot_pkg::*;

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] B_KEY = ADDR_W'(KEY_ADDR_B);

    seq_state_t state_q, state_d;
    logic       set_lock, id_on, id_off;
    logic       hit_a, hit_b;

    assign hit_a = (addr == A_KEY);
    assign hit_b = (addr == B_KEY);

    // Next-state and command-decode logic for the write sequence.
    always_comb begin
        state_d  = state_q;
        set_lock = 1'b0;
        id_on    = 1'b0;
        id_off   = 1'b0;
        if (wr_en) begin
            state_d = SEQ_IDLE;
            unique case (state_q)
                SEQ_IDLE: if (hit_a && data == DATA_W'(KEY_DAT_1)) state_d = SEQ_K1;
                SEQ_K1:   if (hit_b && data == DATA_W'(KEY_DAT_2)) state_d = SEQ_K2;
                SEQ_K2: begin
                    if (hit_a && data == DATA_W'(CMD_LOCK_PRE)) state_d = SEQ_L3;
                    id_on  = hit_a && (data == DATA_W'(CMD_ID_ENTER));
                    id_off = hit_a && (data == DATA_W'(CMD_ID_LEAVE));
                end
                SEQ_L3:   if (hit_a && data == DATA_W'(KEY_DAT_1)) state_d = SEQ_L4;
                SEQ_L4:   if (hit_b && data == DATA_W'(KEY_DAT_2)) state_d = SEQ_L5;
                SEQ_L5:   set_lock = hit_a && (data == DATA_W'(CMD_LOCK_FIN));
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    // Sequence position register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Sticky lockout flag; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= 1'b0;
        else if (set_lock) locked <= 1'b1;
    end

    // Identification mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      id_mode <= 1'b0;
        else if (id_on)  id_mode <= 1'b1;
        else if (id_off) id_mode <= 1'b0;
    end

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    assert_id_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state_q == SEQ_K2 && hit_a && data == DATA_W'(CMD_ID_ENTER)) |=> id_mode);
    assert_lock_only_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && state_q != SEQ_L5) |=> !locked);
endmodule

// File: rtl/bootprot_gate.sv
// Grant logic for program and chip erase requests. A request is granted one
// cycle later when not inhibited; the boot sector additionally needs the lock
// to be clear or the override to be held.
// Assumes requests are single-cycle pulses.
module bootprot_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    input  logic erase_req,
    input  logic inhibit,
    input  logic in_boot,
    input  logic locked,
    input  logic override,
    output logic prog_grant,
    output logic erase_grant,
    output logic erase_boot
);
    logic boot_open;
    assign boot_open = !locked || override;

    // Register the grant decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_grant  <= 1'b0;
            erase_grant <= 1'b0;
            erase_boot  <= 1'b0;
        end else begin
            prog_grant  <= prog_req  && !inhibit && (!in_boot || boot_open);
            erase_grant <= erase_req && !inhibit;
            erase_boot  <= erase_req && !inhibit && boot_open;
        end
    end

    assert_no_grant_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && inhibit) |=> !prog_grant);
    assert_locked_boot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && in_boot && locked && !override) |=> !prog_grant);
    assert_boot_erase_sub_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_boot |-> erase_grant);
endmodule

// File: rtl/bootprot_ctrl.sv
// Top of the boot sector write-protection controller. It forms the inhibit
// term, feeds qualified command writes to the tracker, decodes the boot sector
// and returns the lockout status on identification-mode reads.
// Assumes all electrical conditions arrive as synchronous logic levels.
module bootprot_ctrl #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int BOOT_LOG2 = 14,
    parameter bit BOOT_TOP  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce_act,
    input  logic              we_act,
    input  logic              oe_act,
    input  logic              supply_low,
    input  logic              hv_override,
    output logic              prog_grant,
    output logic              erase_grant,
    output logic              erase_boot,
    output logic              locked,
    output logic              id_mode,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2);

    logic inhibit, in_boot;

    assign inhibit = oe_act || !ce_act || !we_act || supply_low;

    bootprot_range #(.ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .BOOT_TOP(BOOT_TOP)) u_range (
        .addr    (addr),
        .in_boot (in_boot)
    );

    bootprot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_req && !inhibit),
        .addr    (addr),
        .data    (wdata),
        .locked  (locked),
        .id_mode (id_mode)
    );

    bootprot_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_req    (prog_req),
        .erase_req   (erase_req),
        .inhibit     (inhibit),
        .in_boot     (in_boot),
        .locked      (locked),
        .override    (hv_override),
        .prog_grant  (prog_grant),
        .erase_grant (erase_grant),
        .erase_boot  (erase_boot)
    );

    // Status read: lockout flag on bit 0 for the fixed address in ID mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_data  <= '0;
        end else begin
            stat_valid <= rd_req && id_mode && (addr == STAT_ADDR);
            stat_data  <= (rd_req && id_mode && (addr == STAT_ADDR)) ? DATA_W'(locked) : '0;
        end
    end

    assert_stat_needs_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(id_mode));
    assert_erase_keeps_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && locked) |=> locked);
endmodule

// File: tb/tb_bootprot_ctrl.sv
module tb_bootprot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 0, prog_req = 0, erase_req = 0, rd_req = 0;
    logic [19:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ce_act = 1, we_act = 1, oe_act = 0, supply_low = 0, hv_override = 0;
    logic        prog_grant, erase_grant, erase_boot, locked, id_mode, stat_valid;
    logic [7:0]  stat_data;
    logic        t_prog_grant, t_erase_grant, t_erase_boot, t_locked, t_id_mode, t_stat_valid;
    logic [7:0]  t_stat_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bootprot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .prog_req(prog_req),
        .erase_req(erase_req), .rd_req(rd_req), .addr(addr), .wdata(wdata),
        .ce_act(ce_act), .we_act(we_act), .oe_act(oe_act), .supply_low(supply_low),
        .hv_override(hv_override), .prog_grant(prog_grant), .erase_grant(erase_grant),
        .erase_boot(erase_boot), .locked(locked), .id_mode(id_mode),
        .stat_valid(stat_valid), .stat_data(stat_data)
    );

    bootprot_ctrl #(.BOOT_TOP(1'b1)) dut_top (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .prog_req(prog_req),
        .erase_req(erase_req), .rd_req(rd_req), .addr(addr), .wdata(wdata),
        .ce_act(ce_act), .we_act(we_act), .oe_act(oe_act), .supply_low(supply_low),
        .hv_override(hv_override), .prog_grant(t_prog_grant), .erase_grant(t_erase_grant),
        .erase_boot(t_erase_boot), .locked(t_locked), .id_mode(t_id_mode),
        .stat_valid(t_stat_valid), .stat_data(t_stat_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    // Command write: present on a falling edge, remove on the next one.
    task automatic cmd(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_req = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_req = 0;
    endtask

    task automatic prog(input logic [19:0] a);
        @(negedge clk);
        prog_req = 1; addr = a;
        @(negedge clk);
        prog_req = 0;
    endtask

    task automatic erase();
        @(negedge clk);
        erase_req = 1;
        @(negedge clk);
        erase_req = 0;
    endtask

    task automatic rd(input logic [19:0] a);
        @(negedge clk);
        rd_req = 1; addr = a;
        @(negedge clk);
        rd_req = 0;
    endtask

    function automatic bit boot_bot(input logic [19:0] a);
        return a < 20'h04000;
    endfunction

    function automatic bit boot_top(input logic [19:0] a);
        return a >= 20'hFC000;
    endfunction

    // Sweep block starts and ends; lk is the expected lock state.
    task automatic sweep(input bit lk, input string req);
        for (int k = 0; k < 256; k++) begin
            for (int o = 0; o < 2; o++) begin
                logic [19:0] a;
                a = 20'(k * 32'h1000 + o * 32'hFFF);
                prog(a);
                check(req, prog_grant, !(lk && boot_bot(a)));
                check(req, t_prog_grant, !(lk && boot_top(a)));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check("R10", {prog_grant, erase_grant, erase_boot, locked, id_mode, stat_valid}, 0);
        check("R10", stat_data, 0);

        // R1 R2 unlocked sweep: everything granted
        sweep(0, "R2");

        // R3 each inhibit cause
        oe_act = 1; prog(20'h40000); check("R3", prog_grant, 0); oe_act = 0;
        ce_act = 0; prog(20'h40000); check("R3", prog_grant, 0); ce_act = 1;
        we_act = 0; prog(20'h40000); check("R3", prog_grant, 0); we_act = 1;
        supply_low = 1; prog(20'h40000); check("R3", prog_grant, 0);
        erase(); check("R3", erase_grant, 0); supply_low = 0;
        prog(20'h40000); check("R2", prog_grant, 1);

        // R7 ID entry, with an inhibited write in the middle that must be ignored (R3)
        cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55);
        we_act = 0; cmd(20'h01234, 8'h00); we_act = 1;
        check("R3", id_mode, 0);
        cmd(20'h05555, 8'h90);
        check("R7", id_mode, 1);
        check("R7", t_id_mode, 1);

        // R8 status read while unlocked
        rd(20'h00002);
        check("R8", stat_valid, 1); check("R8", stat_data, 8'h00);
        rd(20'h00003);
        check("R8", stat_valid, 0);

        // R5 mismatch in third position: lock sequence must not complete
        cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55); cmd(20'h05555, 8'hA0);
        cmd(20'h05555, 8'h80); cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55);
        cmd(20'h05555, 8'h40);
        check("R5", locked, 0);
        // R5 mismatch in fifth position
        cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55); cmd(20'h05555, 8'h80);
        cmd(20'h05555, 8'hAA); cmd(20'h02AAB, 8'h55); cmd(20'h05555, 8'h40);
        check("R5", locked, 0);

        // R4 full lock sequence
        cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55); cmd(20'h05555, 8'h80);
        cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55);
        check("R4", locked, 0);
        cmd(20'h05555, 8'h40);
        check("R4", locked, 1);
        check("R4", t_locked, 1);

        // R8 status now shows lock
        rd(20'h00002);
        check("R8", stat_valid, 1); check("R8", stat_data, 8'h01);

        // R7 exit
        cmd(20'h05555, 8'hAA); cmd(20'h02AAA, 8'h55); cmd(20'h05555, 8'hF0);
        check("R7", id_mode, 0);
        rd(20'h00002);
        check("R8", stat_valid, 0);

        // R1 R4 locked sweep
        sweep(1, "R4");

        // R6 override
        hv_override = 1;
        prog(20'h00010); check("R6", prog_grant, 1);
        prog(20'hFFFF0); check("R6", t_prog_grant, 1);
        // R9 erase with override reaches the boot sector, lock kept
        erase(); check("R9", erase_grant, 1); check("R9", erase_boot, 1);
        check("R9", locked, 1);
        hv_override = 0;
        prog(20'h00010); check("R6", prog_grant, 0);
        prog(20'hFFFF0); check("R6", t_prog_grant, 0);
        erase(); check("R9", erase_grant, 1); check("R9", erase_boot, 0);
        check("R10", locked, 1);

        // R10 reset clears the lock
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R10", locked, 0); check("R10", t_locked, 0);
        prog(20'h00010); check("R10", prog_grant, 1);

        finish_run();
    end
endmodule